// File: doc/BRIEF.md
# Store Buffer with Load Bypass

This block sits between one in-order processor port and a cache port. Only the write-to-read ordering is relaxed. A store is written into a small FIFO and the processor may go on at once. A later load is sent to the cache ahead of the buffered stores, provided its address differs from the address of every store still held. A load that hits a held address is not forwarded from the buffer. It waits until every store to that address has been written to the cache and acknowledged, and then it goes to the cache.

Buffered stores are written to the cache one by one in the order they were issued. An entry leaves the buffer only when the cache acknowledges its write. The cache port allows one transaction at a time and has variable latency. Each request is completed by exactly one response pulse, and a store's response is its acknowledgement. When the port is free, a load that is ready to go wins over a waiting drain. A drain request that has been presented stays presented, unchanged, until the cache takes it. The occupancy count and an empty flag are brought out.

Top module: `store_bypass_buf`

## Requirements
- R1: A store presented while occupancy is below DEPTH sees `req_ready_o` high in the same cycle, and occupancy rises by one in the next cycle.
- R2: While occupancy equals DEPTH, `req_ready_o` is low for a presented store.
- R3: Buffered stores appear on the cache port (`mem_write_o`=1) in issue order, each with the address and data it was issued with, so that after draining the cache holds the program-order last value of every address.
- R4: `count_o` always equals the number of accepted stores minus the number of write acknowledgements (`mem_rsp_valid_i` pulses that answer a store).
- R5: `empty_o` is high exactly when `count_o` is zero. After reset, `count_o` is 0, `empty_o` is 1, and `mem_valid_o` and `rsp_valid_o` are 0.
- R6: A load whose address matches no buffered store is sent to the cache even while older stores to other addresses are still buffered.
- R7: While any buffered store has the same address as a presented load, `req_ready_o` is low for that load.
- R8: With the cache port free and no drain request held, a presented non-matching load drives the cache request (`mem_write_o`=0, its address), and `req_ready_o` equals `mem_ready_i`.
- R9: A drain request that is presented but not accepted is presented again in the next cycle with the same address and data.
- R10: At most one cache transaction is outstanding, and no request is made between acceptance and response. A response to a load raises `rsp_valid_o` in that same cycle with the cache data. A response to a store does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Processor request accepted |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Store data |
| rsp_valid_o | output | 1 | Load data valid |
| rsp_rdata_o | output | DATA_W | Load data |
| mem_valid_o | output | 1 | Cache request valid |
| mem_ready_i | input | 1 | Cache request accepted |
| mem_write_o | output | 1 | 1 = write (drain), 0 = read |
| mem_addr_o | output | ADDR_W | Cache request address |
| mem_wdata_o | output | DATA_W | Cache write data |
| mem_rsp_valid_i | input | 1 | Cache response, one per accepted request |
| mem_rsp_rdata_i | input | DATA_W | Cache read data |
| empty_o | output | 1 | Buffer holds no store |
| count_o | output | $clog2(DEPTH+1) | Occupancy |

## Verification
The bench builds the block with DEPTH=4, ADDR_W=4 and DATA_W=16. With only 16 addresses, a four-entry buffer often holds a store to the same address as a new load, so stalls happen frequently. Long cache latencies fill the buffer to its limit. A grid of cache latencies (1, 3, 6) is crossed with three acceptance patterns. This drives the full-buffer hold-off, a drain held across a refused request, and loads that overtake stores. Each load's value is checked against a program-order shadow of memory.

// File: rtl/store_bypass_buf_pkg.sv
package store_bypass_buf_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE = 2'd0,
    PORT_LOAD = 2'd1,
    PORT_STORE = 2'd2
  } port_state_e;
endpackage

// File: rtl/sbb_store_queue.sv
module sbb_store_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic              hit_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  hit_vec;
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // parallel compare against every valid entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (addr_q[g] == probe_addr_i);
  end

  assign hit_o       = |hit_vec;
  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];
  assign count_o     = cnt_q;
  assign full_o      = (cnt_q == CNT_W'(DEPTH));
  assign empty_o     = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
      vld_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) begin
        addr_q[wr_ptr_q] <= push_addr_i;
        data_q[wr_ptr_q] <= push_data_i;
        vld_q[wr_ptr_q]  <= 1'b1;
        wr_ptr_q         <= ptr_inc(wr_ptr_q);
      end
      if (pop_i) begin
        vld_q[rd_ptr_q] <= 1'b0;
        rd_ptr_q        <= ptr_inc(rd_ptr_q);
      end
      if (push_i && !pop_i)      cnt_q <= cnt_q + CNT_W'(1);
      else if (!push_i && pop_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/sbb_port_arb.sv
module sbb_port_arb
  import store_bypass_buf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_req_i,
  input  logic st_req_i,
  input  logic mem_ready_i,
  input  logic mem_rsp_valid_i,
  output logic ld_ok_o,
  output logic sel_st_o,
  output logic mem_valid_o,
  output logic retire_o,
  output logic rsp_valid_o
);
  port_state_e state_q, state_d;
  logic        hold_q;
  logic        idle, sel_ld, sel_st;

  assign idle   = (state_q == PORT_IDLE);
  // a held drain keeps the port; otherwise a load goes first
  assign sel_st = idle && st_req_i && (hold_q || !ld_req_i);
  assign sel_ld = idle && ld_req_i && !hold_q;

  assign ld_ok_o     = idle && !hold_q && mem_ready_i;
  assign sel_st_o    = sel_st;
  assign mem_valid_o = sel_st || sel_ld;
  assign retire_o    = (state_q == PORT_STORE) && mem_rsp_valid_i;
  assign rsp_valid_o = (state_q == PORT_LOAD) && mem_rsp_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PORT_IDLE: begin
        if (sel_ld && mem_ready_i)      state_d = PORT_LOAD;
        else if (sel_st && mem_ready_i) state_d = PORT_STORE;
      end
      PORT_LOAD, PORT_STORE: if (mem_rsp_valid_i) state_d = PORT_IDLE;
      default: state_d = PORT_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PORT_IDLE;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= sel_st && !mem_ready_i;
    end
  end
endmodule

// File: rtl/store_bypass_buf.sv
module store_bypass_buf #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_rdata_i,
  output logic              empty_o,
  output logic [CNT_W-1:0]  count_o
);
  logic              push, retire, hit, full, ld_ok, sel_st;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data;

  assign push = req_valid_i && req_write_i && !full;

  sbb_store_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (req_addr_i),
    .push_data_i (req_wdata_i),
    .pop_i       (retire),
    .probe_addr_i(req_addr_i),
    .head_addr_o (head_addr),
    .head_data_o (head_data),
    .hit_o       (hit),
    .full_o      (full),
    .empty_o     (empty_o),
    .count_o     (count_o)
  );

  sbb_port_arb u_arb (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ld_req_i       (req_valid_i && !req_write_i && !hit),
    .st_req_i       (!empty_o),
    .mem_ready_i    (mem_ready_i),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .ld_ok_o        (ld_ok),
    .sel_st_o       (sel_st),
    .mem_valid_o    (mem_valid_o),
    .retire_o       (retire),
    .rsp_valid_o    (rsp_valid_o)
  );

  assign req_ready_o = req_write_i ? !full : (ld_ok && !hit);
  assign mem_write_o = sel_st;
  assign mem_addr_o  = sel_st ? head_addr : req_addr_i;
  assign mem_wdata_o = head_data;
  assign rsp_rdata_o = mem_rsp_rdata_i;
endmodule

// File: rtl/store_bypass_buf_chk.sv
module store_bypass_buf_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_write_i,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic              mem_write_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              empty_o,
  input logic [CNT_W-1:0]  count_o
);
  assert_full_blocks_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && count_o == CNT_W'(DEPTH)) |-> !req_ready_o);

  assert_store_lands_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_ready_o) |=> !empty_o);

  assert_count_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));

  assert_drain_needs_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_write_o) |-> (count_o != '0));

  assert_drain_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_write_o && !mem_ready_i)
      |=> (mem_valid_o && mem_write_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));
endmodule

bind store_bypass_buf store_bypass_buf_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_write_i(req_write_i),
  .mem_valid_o(mem_valid_o),
  .mem_ready_i(mem_ready_i),
  .mem_write_o(mem_write_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .empty_o    (empty_o),
  .count_o    (count_o)
);

// File: tb/test_store_bypass_buf.sv
module test_store_bypass_buf;
  localparam int DEPTH = 4, AW = 4, DW = 16, NA = 16, NOPS = 64, CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid_i = 0, req_write_i = 0, req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          rsp_valid_o;
  logic [DW-1:0] rsp_rdata_o;
  logic          mem_valid_o, mem_write_o, mem_ready_i = 0, mem_rsp_valid_i = 0;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rsp_rdata_i = '0;
  logic          empty_o;
  logic [CW-1:0] count_o;

  store_bypass_buf #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) i_store_bypass_buf (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_write_o(mem_write_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_rdata_i(mem_rsp_rdata_i),
    .empty_o(empty_o), .count_o(count_o)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench models
  logic [DW-1:0] shadow [NA];
  logic [DW-1:0] cmem [NA];
  logic [AW-1:0] pa [NOPS];
  logic [DW-1:0] pd [NOPS];
  logic [DW-1:0] le [NOPS];
  int ph, pt, lh, lt;
  bit c_busy, c_wr, hold_prev;
  int c_cnt;
  logic [AW-1:0] c_addr, hold_addr;
  logic [DW-1:0] c_data, hold_data;
  bit o_wr [NOPS];
  logic [AW-1:0] o_addr [NOPS];
  logic [DW-1:0] o_dat [NOPS];
  int op_i, cyc, n_bypass, n_stall, n_full;

  task automatic cycle(int lat, int mode);
    int pend;
    bit match;
    @(posedge clk); #1;
    if (op_i < NOPS) begin
      req_valid_i = 1; req_write_i = o_wr[op_i];
      req_addr_i = o_addr[op_i]; req_wdata_i = o_dat[op_i];
    end else req_valid_i = 0;
    mem_rsp_valid_i = 0;
    if (c_busy) begin
      if (c_cnt == 0) begin
        mem_rsp_valid_i = 1;
        mem_rsp_rdata_i = c_wr ? '0 : cmem[c_addr];
      end else c_cnt--;
    end
    mem_ready_i = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : ((cyc % 3) != 0);
    #2;
    pend = pt - ph;
    match = 0;
    for (int k = ph; k < pt; k++) if (pa[k % NOPS] == req_addr_i) match = 1;
    chk(count_o == CW'(pend), "R4", "count", int'(count_o), pend);
    chk(empty_o == (pend == 0), "R5", "empty", int'(empty_o), int'(pend == 0));
    if (req_valid_i && req_write_i) begin
      if (pend < DEPTH) chk(req_ready_o, "R1", "store ready", int'(req_ready_o), 1);
      else begin
        chk(!req_ready_o, "R2", "store ready when full", int'(req_ready_o), 0);
        n_full++;
      end
    end
    if (req_valid_i && !req_write_i && match) begin
      chk(!req_ready_o, "R7", "matching load ready", int'(req_ready_o), 0);
      n_stall++;
    end
    if (c_busy && !mem_rsp_valid_i)
      chk(!mem_valid_o, "R10", "request while outstanding", int'(mem_valid_o), 0);
    else if (!c_busy) begin
      if (hold_prev)
        chk(mem_valid_o && mem_write_o && mem_addr_o == hold_addr && mem_wdata_o == hold_data,
            "R9", "held drain addr", int'(mem_addr_o), int'(hold_addr));
      else if (req_valid_i && !req_write_i && !match)
        chk(mem_valid_o && !mem_write_o && mem_addr_o == req_addr_i && req_ready_o == mem_ready_i,
            "R8", "load priority addr", int'(mem_addr_o), int'(req_addr_i));
      else if (pend > 0)
        chk(mem_valid_o && mem_write_o, "R3", "drain request", int'(mem_valid_o), 1);
      else
        chk(!mem_valid_o, "R10", "idle port", int'(mem_valid_o), 0);
    end
    if (mem_rsp_valid_i) begin
      if (c_wr) begin
        chk(!rsp_valid_o, "R10", "rsp on write ack", int'(rsp_valid_o), 0);
        cmem[c_addr] = c_data;
        ph++;
      end else begin
        chk(rsp_valid_o && rsp_rdata_o == le[lh % NOPS], "R10", "load data",
            int'(rsp_rdata_o), int'(le[lh % NOPS]));
        lh++;
      end
      c_busy = 0;
    end else chk(!rsp_valid_o, "R10", "spurious rsp", int'(rsp_valid_o), 0);
    if (mem_valid_o && mem_ready_i) begin
      c_busy = 1; c_cnt = lat - 1; c_wr = mem_write_o;
      c_addr = mem_addr_o; c_data = mem_wdata_o;
      if (mem_write_o)
        chk(mem_addr_o == pa[ph % NOPS] && mem_wdata_o == pd[ph % NOPS], "R3", "drain order addr",
            int'(mem_addr_o), int'(pa[ph % NOPS]));
    end
    hold_prev = mem_valid_o && mem_write_o && !mem_ready_i;
    hold_addr = mem_addr_o; hold_data = mem_wdata_o;
    if (req_valid_i && req_ready_o) begin
      if (req_write_i) begin
        pa[pt % NOPS] = req_addr_i; pd[pt % NOPS] = req_wdata_i; pt++;
        shadow[req_addr_i] = req_wdata_i;
      end else begin
        le[lt % NOPS] = shadow[req_addr_i]; lt++;
        if (pend > 0) n_bypass++;
      end
      op_i++;
    end
    cyc++;
  endtask

  task automatic run(int lat, int mode, int seed);
    int st = seed, wd = 0;
    for (int k = 0; k < NOPS; k++) begin
      st = (st * 1103515245 + 12345) & 32'h7fffffff;
      o_wr[k]   = (k < NOPS / 2) ? (st[5:4] != 0) : (st[5:4] == 0);
      o_addr[k] = st[11:8];
      o_dat[k]  = st[27:12];
    end
    op_i = 0;
    while ((op_i < NOPS || lh != lt || ph != pt || c_busy) && wd < 5000) begin
      cycle(lat, mode);
      wd++;
    end
    chk(wd < 5000, "WDOG", "run timeout", wd, 5000);
    for (int a = 0; a < NA; a++)
      chk(cmem[a] == shadow[a], "R3", "final memory", int'(cmem[a]), int'(shadow[a]));
  endtask

  initial begin
    for (int a = 0; a < NA; a++) begin shadow[a] = '0; cmem[a] = '0; end
    ph = 0; pt = 0; lh = 0; lt = 0; c_busy = 0; c_wr = 0; c_cnt = 0; hold_prev = 0;
    c_addr = '0; c_data = '0; hold_addr = '0; hold_data = '0;
    cyc = 0; n_bypass = 0; n_stall = 0; n_full = 0;
    repeat (2) @(posedge clk);
    #1;
    chk(empty_o && count_o == '0, "R5", "reset empty/count", int'(count_o), 0);
    chk(!mem_valid_o && !rsp_valid_o, "R5", "reset port idle", int'(mem_valid_o), 0);
    rst_ni = 1'b1;
    for (int lat = 1; lat <= 6; lat += (lat == 1) ? 2 : 3)
      for (int mode = 0; mode < 3; mode++)
        run(lat, mode, 17 + lat * 31 + mode * 7);
    chk(n_bypass > 0, "R6", "loads overtaking stores", n_bypass, 1);
    chk(n_stall > 0, "R7", "matching loads held", n_stall, 1);
    chk(n_full > 0, "R2", "full condition reached", n_full, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule